// File: doc/BRIEF.md
# Per-Channel Sum and Timing Frame Encoder

This block turns per-tick hit reports from a bank of ADC channels into a fixed-length trigger frame. A frame spans eight ticks of the 4 ns sample clock and holds one byte for every channel. Each byte packs a compressed pulse sum with a code naming the tick within the frame where that channel first saw a usable hit. The frame for one window is collected while that window runs and is sent during the next window. Two bytes leave per clock, so sixteen bytes fill the eight ticks exactly, and a frame-start strobe marks the first pair.

A matching decoder sits on the same byte stream. It counts frame-start strobes to keep a running frame number and turns each nonzero byte back into a channel number, a sum and an absolute tick. Downstream trigger logic can use it directly. It also shows that every encoded field survives the round trip unchanged.

Top module: `chan_frame_packer`

## Requirements
- R1: `tx_sof_o` is high in the first clock of each transmitted frame and then low for the following seven clocks. In the clock that carries slot k (k = 0..7, where k = 0 is the clock with `tx_sof_o` high), lane 0 (`tx_bytes_o[7:0]`) carries channel 2k and lane 1 (`tx_bytes_o[15:8]`) carries channel 2k+1.
- R2: A channel byte carries the sum in bits [7:3] and the tick code in bits [2:0]. The tick code is the tick within the frame (0..7) at which the encoded hit was sampled.
- R3: The encoded sum equals the channel's pulse sum shifted right by `shift_i`, saturated at 31.
- R4: A hit whose compressed sum is 0 is not encoded, and it does not stop a later hit of the same channel in the same frame from being encoded.
- R5: When a channel has several usable hits in one frame, only the first one is encoded.
- R6: A channel with no usable hit in a frame sends the byte 0x00.
- R7: Frame n collects the inputs sampled at clock edges 8n to 8n+7 after reset release. It is transmitted in the eight clocks that follow edges 8n+8 to 8n+15. Before the first frame is complete, the byte outputs are zero and `tx_sof_o` stays low.
- R8: While `rst_n` is low, `tx_bytes_o`, `tx_sof_o` and `dec_hit_o` are all zero.
- R9: One clock after a byte with a nonzero sum appears on a lane, the decoder raises that lane's `dec_hit_o` bit. At the same time it reports the channel number from R1, the sum, and the absolute tick F*8 + code, taken modulo 2^ABS_W. F is the frame number, counted from 0 at the first frame-start after reset.
- R10: A hit sampled in the last tick of a frame (code 7) belongs to that frame and does not appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_i | input | SHIFT_W | Right-shift applied to pulse sums before saturation |
| hit_i | input | NCH | Per-channel hit flag for the current tick |
| psum_i | input | NCH*PSUM_W | Per-channel pulse sum; channel c at bits [c*PSUM_W +: PSUM_W] |
| tx_bytes_o | output | LANES*(SUM_W+CODE_W) | Two channel bytes per clock, lane 0 in the low byte |
| tx_sof_o | output | 1 | Frame-start strobe, high with slot 0 |
| dec_hit_o | output | LANES | Decoded hit flag per lane |
| dec_chan_o | output | LANES*CH_W | Decoded channel number per lane |
| dec_sum_o | output | LANES*SUM_W | Decoded sum per lane |
| dec_tick_o | output | LANES*ABS_W | Decoded absolute tick per lane |

## Verification
The bench builds the block with 16 channels, 8 ticks per frame, 12-bit pulse sums, a 3-bit shift and an 8-bit absolute tick. With a 12-bit sum, saturation is reached at small shifts, and the largest shift still covers the full 5-bit range. The 8-bit tick leaves a 5-bit frame counter, so the decoder's frame number wraps many times within a short run and the wrap of the reconstructed tick gets checked. Random traffic at several densities and shifts is mixed with a hand-built frame that tests first-hit priority, sums that compress to zero, the last-tick boundary and a reset taken mid-stream.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int unsigned DEF_NCH     = 16;
  localparam int unsigned DEF_TICKS   = 8;
  localparam int unsigned DEF_PSUM_W  = 16;
  localparam int unsigned DEF_SHIFT_W = 4;
  localparam int unsigned DEF_SUM_W   = 5;
  localparam int unsigned DEF_ABS_W   = 24;
endpackage

// File: rtl/cfp_tick_ctr.sv
module cfp_tick_ctr #(
  parameter int unsigned TICKS  = 8,
  parameter int unsigned CODE_W = $clog2(TICKS)
)(
  input  logic              clk,
  input  logic              rst_n,
  output logic [CODE_W-1:0] tick_o,
  output logic              frame_last_o,
  output logic              live_o
);
  logic [CODE_W-1:0] tick_q, tick_n;
  logic              live_q, live_n;
  logic              last;

  always_comb begin
    last   = (tick_q == CODE_W'(TICKS - 1));
    tick_n = last ? '0 : tick_q + 1'b1;
    live_n = live_q | last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      live_q <= 1'b0;
    end else begin
      tick_q <= tick_n;
      live_q <= live_n;
    end
  end

  assign tick_o       = tick_q;
  assign frame_last_o = last;
  assign live_o       = live_q;
endmodule

// File: rtl/cfp_chan_slot.sv
module cfp_chan_slot #(
  parameter int unsigned PSUM_W  = 16,
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned SUM_W   = 5,
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned BYTE_W  = SUM_W + CODE_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic [PSUM_W-1:0]  psum_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [CODE_W-1:0]  tick_i,
  input  logic               frame_last_i,
  output logic [BYTE_W-1:0]  img_o
);
  logic [PSUM_W-1:0] shifted;
  logic [SUM_W-1:0]  comp;
  logic              take;

  logic              have_q, have_n;
  logic [SUM_W-1:0]  sum_q, sum_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [BYTE_W-1:0] img_q, img_n;
  logic              cap_en, img_en;

  // compression: shift then saturate to the field width
  always_comb begin
    shifted = psum_i >> shift_i;
    comp    = (|shifted[PSUM_W-1:SUM_W]) ? '1 : shifted[SUM_W-1:0];
    take    = hit_i && (comp != '0) && !have_q;
  end

  // next state: first usable hit wins, image handed over on the last tick
  always_comb begin
    have_n = have_q;
    sum_n  = sum_q;
    code_n = code_q;
    img_n  = img_q;
    cap_en = frame_last_i | take;
    img_en = frame_last_i;
    if (frame_last_i) begin
      have_n = 1'b0;
      sum_n  = '0;
      code_n = '0;
      img_n  = take ? {comp, tick_i} : {sum_q, code_q};
    end else if (take) begin
      have_n = 1'b1;
      sum_n  = comp;
      code_n = tick_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      sum_q  <= '0;
      code_q <= '0;
    end else if (cap_en) begin
      have_q <= have_n;
      sum_q  <= sum_n;
      code_q <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      img_q <= '0;
    else if (img_en) img_q <= img_n;
  end

  assign img_o = img_q;
endmodule

// File: rtl/cfp_lane_mux.sv
module cfp_lane_mux #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned TICKS  = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CODE_W = $clog2(TICKS),
  parameter int unsigned LANES  = NCH / TICKS,
  parameter int unsigned CH_W   = $clog2(NCH)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       img_i [NCH],
  input  logic [CODE_W-1:0]       tick_i,
  input  logic                    live_i,
  output logic [LANES*BYTE_W-1:0] bytes_o,
  output logic                    sof_o
);
  logic [LANES*BYTE_W-1:0] bytes_q, bytes_n;
  logic                    sof_q, sof_n;

  always_comb begin
    bytes_n = '0;
    for (int j = 0; j < LANES; j++) begin
      if (live_i)
        bytes_n[j*BYTE_W +: BYTE_W] = img_i[CH_W'(int'(tick_i) * LANES + j)];
    end
    sof_n = live_i && (tick_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      sof_q   <= 1'b0;
    end else begin
      bytes_q <= bytes_n;
      sof_q   <= sof_n;
    end
  end

  assign bytes_o = bytes_q;
  assign sof_o   = sof_q;
endmodule

// File: rtl/cfp_frame_decoder.sv
module cfp_frame_decoder #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned TICKS  = 8,
  parameter int unsigned SUM_W  = 5,
  parameter int unsigned ABS_W  = 24,
  parameter int unsigned CODE_W = $clog2(TICKS),
  parameter int unsigned BYTE_W = SUM_W + CODE_W,
  parameter int unsigned LANES  = NCH / TICKS,
  parameter int unsigned CH_W   = $clog2(NCH),
  parameter int unsigned FRM_W  = ABS_W - CODE_W
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof_i,
  input  logic [LANES*BYTE_W-1:0] bytes_i,
  output logic [LANES-1:0]        hit_o,
  output logic [LANES*CH_W-1:0]   chan_o,
  output logic [LANES*SUM_W-1:0]  sum_o,
  output logic [LANES*ABS_W-1:0]  tick_o
);
  logic [FRM_W-1:0]  fcnt_q, fcnt_n;
  logic [FRM_W-1:0]  cur_q, cur_n;
  logic [CODE_W-1:0] slot_q, slot_n;
  logic              seen_q, seen_n;

  logic [LANES-1:0]       hit_q, hit_n;
  logic [LANES*CH_W-1:0]  chan_q, chan_n;
  logic [LANES*SUM_W-1:0] sum_q, sum_n;
  logic [LANES*ABS_W-1:0] tick_q, tick_n;

  always_comb begin
    cur_n  = sof_i ? fcnt_q : cur_q;
    fcnt_n = sof_i ? fcnt_q + 1'b1 : fcnt_q;
    slot_n = sof_i ? '0 : slot_q + 1'b1;
    seen_n = sof_i | seen_q;
    for (int j = 0; j < LANES; j++) begin
      hit_n[j] = seen_n && (bytes_i[j*BYTE_W+CODE_W +: SUM_W] != '0);
      chan_n[j*CH_W +: CH_W]   = CH_W'(int'(slot_n) * LANES + j);
      sum_n[j*SUM_W +: SUM_W]  = bytes_i[j*BYTE_W+CODE_W +: SUM_W];
      tick_n[j*ABS_W +: ABS_W] = {cur_n, bytes_i[j*BYTE_W +: CODE_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      cur_q  <= '0;
      slot_q <= '0;
      seen_q <= 1'b0;
      hit_q  <= '0;
    end else begin
      fcnt_q <= fcnt_n;
      cur_q  <= cur_n;
      slot_q <= slot_n;
      seen_q <= seen_n;
      hit_q  <= hit_n;
    end
  end

  // field registers only load for lanes that carry a hit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      sum_q  <= '0;
      tick_q <= '0;
    end else begin
      for (int j = 0; j < LANES; j++) begin
        if (hit_n[j]) begin
          chan_q[j*CH_W +: CH_W]   <= chan_n[j*CH_W +: CH_W];
          sum_q[j*SUM_W +: SUM_W]  <= sum_n[j*SUM_W +: SUM_W];
          tick_q[j*ABS_W +: ABS_W] <= tick_n[j*ABS_W +: ABS_W];
        end
      end
    end
  end

  assign hit_o  = hit_q;
  assign chan_o = chan_q;
  assign sum_o  = sum_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/chan_frame_packer.sv
module chan_frame_packer
  import cfp_pkg::*;
#(
  parameter int unsigned NCH         = DEF_NCH,
  parameter int unsigned FRAME_TICKS = DEF_TICKS,
  parameter int unsigned PSUM_W      = DEF_PSUM_W,
  parameter int unsigned SHIFT_W     = DEF_SHIFT_W,
  parameter int unsigned SUM_W       = DEF_SUM_W,
  parameter int unsigned ABS_W       = DEF_ABS_W,
  localparam int unsigned CODE_W     = $clog2(FRAME_TICKS),
  localparam int unsigned BYTE_W     = SUM_W + CODE_W,
  localparam int unsigned LANES      = NCH / FRAME_TICKS,
  localparam int unsigned CH_W       = $clog2(NCH)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic [NCH-1:0]          hit_i,
  input  logic [NCH*PSUM_W-1:0]   psum_i,
  output logic [LANES*BYTE_W-1:0] tx_bytes_o,
  output logic                    tx_sof_o,
  output logic [LANES-1:0]        dec_hit_o,
  output logic [LANES*CH_W-1:0]   dec_chan_o,
  output logic [LANES*SUM_W-1:0]  dec_sum_o,
  output logic [LANES*ABS_W-1:0]  dec_tick_o
);
  logic [CODE_W-1:0] tick;
  logic              frame_last;
  logic              live;
  logic [BYTE_W-1:0] img [NCH];

  cfp_tick_ctr #(.TICKS(FRAME_TICKS), .CODE_W(CODE_W)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .tick_o(tick), .frame_last_o(frame_last), .live_o(live)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cfp_chan_slot #(
      .PSUM_W(PSUM_W), .SHIFT_W(SHIFT_W), .SUM_W(SUM_W),
      .CODE_W(CODE_W), .BYTE_W(BYTE_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .hit_i(hit_i[c]),
      .psum_i(psum_i[c*PSUM_W +: PSUM_W]),
      .shift_i(shift_i),
      .tick_i(tick),
      .frame_last_i(frame_last),
      .img_o(img[c])
    );
  end

  cfp_lane_mux #(
    .NCH(NCH), .TICKS(FRAME_TICKS), .BYTE_W(BYTE_W),
    .CODE_W(CODE_W), .LANES(LANES), .CH_W(CH_W)
  ) u_mux (
    .clk(clk), .rst_n(rst_n),
    .img_i(img), .tick_i(tick), .live_i(live),
    .bytes_o(tx_bytes_o), .sof_o(tx_sof_o)
  );

  cfp_frame_decoder #(
    .NCH(NCH), .TICKS(FRAME_TICKS), .SUM_W(SUM_W), .ABS_W(ABS_W),
    .CODE_W(CODE_W), .BYTE_W(BYTE_W), .LANES(LANES), .CH_W(CH_W),
    .FRM_W(ABS_W - CODE_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .sof_i(tx_sof_o), .bytes_i(tx_bytes_o),
    .hit_o(dec_hit_o), .chan_o(dec_chan_o),
    .sum_o(dec_sum_o), .tick_o(dec_tick_o)
  );
endmodule

// File: rtl/chan_frame_packer_chk.sv
module chan_frame_packer_chk #(
  parameter int unsigned FRAME_TICKS = 8,
  parameter int unsigned LANES       = 2,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SUM_W       = 5,
  parameter int unsigned CODE_W      = 3
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*BYTE_W-1:0] tx_bytes_o,
  input logic                    tx_sof_o,
  input logic [LANES-1:0]        dec_hit_o,
  input logic [LANES*SUM_W-1:0]  dec_sum_o
);
  localparam logic [CODE_W:0] LIM = (CODE_W+1)'(FRAME_TICKS);

  logic [CODE_W:0] gap_q;
  logic [CODE_W:0] age_q;
  logic            seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      age_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= tx_sof_o ? '0 : ((gap_q == LIM) ? gap_q : gap_q + 1'b1);
      age_q  <= (age_q == LIM) ? age_q : age_q + 1'b1;
      seen_q <= seen_q | tx_sof_o;
    end
  end

  // R1: frame-start strobes are exactly one frame apart
  a_r1_sof_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof_o && seen_q) |-> (gap_q == LIM - 1'b1));

  // R7: nothing is framed before the first frame has been collected
  a_r7_quiet_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < LIM) |-> !tx_sof_o);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    // R6: a byte without a sum carries no tick code either
    a_r6_empty_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bytes_o[j*BYTE_W+CODE_W +: SUM_W] == '0) |-> (tx_bytes_o[j*BYTE_W +: CODE_W] == '0));

    // R9: a decoded hit reproduces the nonzero sum sent one clock earlier
    a_r9_dec_sum: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit_o[j] |-> ((dec_sum_o[j*SUM_W +: SUM_W] == $past(tx_bytes_o[j*BYTE_W+CODE_W +: SUM_W]))
                        && ($past(tx_bytes_o[j*BYTE_W+CODE_W +: SUM_W]) != '0)));
  end
endmodule

bind chan_frame_packer chan_frame_packer_chk #(
  .FRAME_TICKS(FRAME_TICKS), .LANES(LANES), .BYTE_W(BYTE_W),
  .SUM_W(SUM_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_bytes_o(tx_bytes_o), .tx_sof_o(tx_sof_o),
  .dec_hit_o(dec_hit_o), .dec_sum_o(dec_sum_o)
);

// File: tb/chan_frame_packer_test.sv
`timescale 1ns/1ps
module chan_frame_packer_test;
  localparam int NCH = 16, TICKS = 8, PSUM_W = 12, SHIFT_W = 3, SUM_W = 5, ABS_W = 8;
  localparam int LANES = 2, CH_W = 4, BYTE_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst_n;
  logic [SHIFT_W-1:0]      shift;
  logic [NCH-1:0]          hit;
  logic [NCH*PSUM_W-1:0]   psum;
  logic [LANES*BYTE_W-1:0] tx_bytes;
  logic                    tx_sof;
  logic [LANES-1:0]        dec_hit;
  logic [LANES*CH_W-1:0]   dec_chan;
  logic [LANES*SUM_W-1:0]  dec_sum;
  logic [LANES*ABS_W-1:0]  dec_tick;

  chan_frame_packer #(
    .NCH(NCH), .FRAME_TICKS(TICKS), .PSUM_W(PSUM_W), .SHIFT_W(SHIFT_W),
    .SUM_W(SUM_W), .ABS_W(ABS_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .shift_i(shift), .hit_i(hit), .psum_i(psum),
    .tx_bytes_o(tx_bytes), .tx_sof_o(tx_sof), .dec_hit_o(dec_hit),
    .dec_chan_o(dec_chan), .dec_sum_o(dec_sum), .dec_tick_o(dec_tick)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       ne;
  bit [7:0] cur_img [NCH];
  bit [7:0] prev_img [NCH];
  bit       cur_have [NCH];
  bit       exp_valid, exp_sof;
  bit [7:0] exp_b [LANES];
  int       exp_k, exp_n;
  bit       prv_valid;
  bit [7:0] prv_b [LANES];
  int       prv_k, prv_n;
  bit       e_dhit [LANES];
  int       e_dchan [LANES], e_dsum [LANES], e_dtick [LANES];

  always @(posedge clk) begin
    if (!rst_n) begin
      ne = 0;
      exp_valid = 0; exp_sof = 0; prv_valid = 0;
      exp_k = 0; exp_n = 0; prv_k = 0; prv_n = 0;
      for (int c = 0; c < NCH; c++) begin
        cur_img[c] = 0; prev_img[c] = 0; cur_have[c] = 0;
      end
      for (int j = 0; j < LANES; j++) begin
        exp_b[j] = 0; prv_b[j] = 0; e_dhit[j] = 0;
      end
    end else begin
      int tk;
      for (int j = 0; j < LANES; j++) begin
        e_dhit[j]  = prv_valid && (prv_b[j][7:3] != 0);
        e_dchan[j] = prv_k * LANES + j;
        e_dsum[j]  = prv_b[j][7:3];
        e_dtick[j] = (prv_n * TICKS + prv_b[j][2:0]) % (1 << ABS_W);
      end
      if (ne >= TICKS) begin
        exp_valid = 1;
        exp_n = ne / TICKS - 1;
        exp_k = ne % TICKS;
        exp_sof = (exp_k == 0);
        for (int j = 0; j < LANES; j++) exp_b[j] = prev_img[exp_k * LANES + j];
      end else begin
        exp_valid = 0; exp_sof = 0;
        for (int j = 0; j < LANES; j++) exp_b[j] = 0;
      end
      prv_valid = exp_valid; prv_k = exp_k; prv_n = exp_n;
      for (int j = 0; j < LANES; j++) prv_b[j] = exp_b[j];
      tk = ne % TICKS;
      for (int c = 0; c < NCH; c++) begin
        if (hit[c]) begin
          int v;
          v = int'(psum[c*PSUM_W +: PSUM_W]) >> shift;
          if (v > 31) v = 31;
          if (v != 0 && !cur_have[c]) begin
            cur_have[c] = 1;
            cur_img[c] = {v[4:0], tk[2:0]};
          end
        end
      end
      if (tk == TICKS - 1) begin
        for (int c = 0; c < NCH; c++) begin
          prev_img[c] = cur_img[c]; cur_img[c] = 0; cur_have[c] = 0;
        end
      end
      ne++;
    end
  end

  // ---------------- comparison every clock ----------------
  task automatic compare_all();
    chk(tx_sof == exp_sof, exp_valid ? "R1 frame-start" : "R7 no frame-start before first frame",
        int'(tx_sof), int'(exp_sof));
    for (int j = 0; j < LANES; j++) begin
      bit [7:0] a;
      a = tx_bytes[j*BYTE_W +: BYTE_W];
      if (exp_b[j] == 0)
        chk(a == 0, exp_valid ? "R6 empty channel byte" : "R7 zero bytes before first frame", int'(a), 0);
      else begin
        chk(a[7:3] == exp_b[j][7:3], "R3 compressed sum", int'(a[7:3]), int'(exp_b[j][7:3]));
        chk(a[2:0] == exp_b[j][2:0], "R2 tick code", int'(a[2:0]), int'(exp_b[j][2:0]));
      end
      chk(dec_hit[j] == e_dhit[j], "R9 decoder hit flag", int'(dec_hit[j]), int'(e_dhit[j]));
      if (e_dhit[j]) begin
        chk(int'(dec_chan[j*CH_W +: CH_W]) == e_dchan[j], "R9 decoded channel",
            int'(dec_chan[j*CH_W +: CH_W]), e_dchan[j]);
        chk(int'(dec_sum[j*SUM_W +: SUM_W]) == e_dsum[j], "R9 decoded sum",
            int'(dec_sum[j*SUM_W +: SUM_W]), e_dsum[j]);
        chk(int'(dec_tick[j*ABS_W +: ABS_W]) == e_dtick[j], "R9 decoded absolute tick",
            int'(dec_tick[j*ABS_W +: ABS_W]), e_dtick[j]);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare_all();
    else begin
      chk(tx_bytes == 0, "R8 bytes in reset", int'(tx_bytes), 0);
      chk(tx_sof == 0, "R8 frame-start in reset", int'(tx_sof), 0);
      chk(dec_hit == 0, "R8 decoder hits in reset", int'(dec_hit), 0);
    end
  endtask

  task automatic drive_random(int density, int maxps);
    for (int c = 0; c < NCH; c++) begin
      hit[c] = (($urandom % 100) < density);
      psum[c*PSUM_W +: PSUM_W] = PSUM_W'($urandom % maxps);
    end
  endtask

  task automatic set_ch(int c, int p);
    hit[c] = 1'b1;
    psum[c*PSUM_W +: PSUM_W] = PSUM_W'(p);
  endtask

  task automatic wait_to(int t);
    while (ne < t) step();
  endtask

  task automatic lane_is(int lane, int exp, string tag);
    chk(int'(tx_bytes[lane*BYTE_W +: BYTE_W]) == exp, tag, int'(tx_bytes[lane*BYTE_W +: BYTE_W]), exp);
  endtask

  task automatic directed_frame();
    int base;
    hit = '0; psum = '0; shift = 3'd2;
    do step(); while (ne % TICKS != 0);
    base = ne;
    for (int k = 0; k < TICKS; k++) begin
      hit = '0;
      case (k)
        1: set_ch(4, 3);      // compresses to 0: ignored
        2: set_ch(3, 40);     // first hit of ch3 -> 10
        3: set_ch(6, 2);      // compresses to 0 and nothing follows
        4: set_ch(4, 28);     // usable hit of ch4 -> 7
        5: set_ch(3, 80);     // second hit of ch3: dropped
        7: set_ch(15, 1000);  // last tick, saturates
        default: ;
      endcase
      step();
    end
    hit = '0;
    wait_to(base + 9);
    chk(tx_sof == 1'b1, "R1 frame-start with slot 0", int'(tx_sof), 1);
    lane_is(0, 0, "R6 channel 0 without hit");
    wait_to(base + 10);
    lane_is(1, 8'h52, "R5 first hit of channel 3 kept");
    wait_to(base + 11);
    lane_is(0, 8'h3C, "R4 channel 4 skips zero-sum hit");
    chk(dec_hit[1] == 1'b1, "R9 directed decoder hit", int'(dec_hit[1]), 1);
    chk(int'(dec_chan[CH_W +: CH_W]) == 3, "R9 directed channel", int'(dec_chan[CH_W +: CH_W]), 3);
    chk(int'(dec_sum[SUM_W +: SUM_W]) == 10, "R9 directed sum", int'(dec_sum[SUM_W +: SUM_W]), 10);
    wait_to(base + 12);
    lane_is(0, 0, "R4 channel 6 zero-sum hit not encoded");
    wait_to(base + 16);
    lane_is(1, 8'hFF, "R10 last-tick hit in its own frame with R3 saturation");
    wait_to(base + 24);
    lane_is(1, 0, "R10 last-tick hit not carried to next frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit = '0; psum = '0; shift = '0;
    repeat (3) step();
    rst_n = 1'b1;
    shift = 3'd0;
    repeat (300) begin step(); drive_random(30, 64); end
    shift = 3'd3;
    repeat (300) begin step(); drive_random(60, 4096); end
    shift = 3'd7;
    repeat (300) begin step(); drive_random(80, 4096); end
    directed_frame();
    step();
    rst_n = 1'b0; hit = '0;
    step(); step();
    rst_n = 1'b1;
    shift = 3'd1;
    repeat (300) begin step(); drive_random(40, 128); end
    hit = '0;
    repeat (24) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule